// File: doc/BRIEF.md
# RAM Write Protection Unit

This unit guards the write paths of two bus masters that share one RAM: a main CPU and a coprocessor. Software programs two address windows through a small register bus. The first window is private to the coprocessor. The second window is shared by both masters. Software then turns protection on. From that point the CPU may not write into the private window. The coprocessor may write only inside its private window or the shared window. Any other write is suppressed.

Each master presents a write strobe and an address. The unit answers in the same cycle with a write-allow signal, which gates the RAM write. A blocked CPU write sets a sticky violation flag, and software clears that flag by writing a one to it. When interrupts are enabled, the flag drives an interrupt line. Blocked coprocessor writes are dropped without being recorded. While protection is on, the window bounds are frozen, so a running program cannot widen its own access.

Top module: `ram_write_guard`

## Requirements
- R1: The control register sits at register offset 0x11C. Bit 7 is the protection enable, bit 1 is the interrupt enable and bit 0 is the violation flag. Bits 6 to 2 always read as zero. The register reads back zero-extended to the bus width.
- R2: After reset, the control register and all four bound registers read zero, and irq is low.
- R3: While protection is disabled, each write-allow output equals its master's write strobe, and no CPU write sets the flag.
- R4: The bound registers sit at offsets 0x11D (coprocessor low), 0x11E (coprocessor high), 0x11F (shared low) and 0x120 (shared high). Each holds the low RAM_AW bits of the written data. They accept writes only while protection is disabled. While it is enabled, writes to them are ignored.
- R5: With protection enabled, a CPU write whose address lies within the coprocessor window is suppressed. A CPU write to any other address is allowed. Both window ends count as inside.
- R6: With protection enabled, a coprocessor write is allowed only when its address lies within the coprocessor window or the shared window, ends included.
- R7: A suppressed CPU write sets the violation flag at the next clock edge. A suppressed coprocessor write leaves the flag unchanged.
- R8: Writing the control register with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag unchanged. If a CPU violation occurs in the same cycle as a clearing write, the flag ends up set.
- R9: irq is high exactly when the interrupt enable and the violation flag are both 1.
- R10: A window whose low bound is greater than its high bound contains no address.
- R11: Write-allow outputs depend combinationally on the current strobe and address, and are low whenever their strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register bus access select |
| regWrite | input | 1 | Register bus write (1) or read (0) |
| regAddr | input | REG_AW | Register offset |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data, zero when not selected |
| cpuWrEn | input | 1 | CPU RAM write strobe |
| cpuAddr | input | RAM_AW | CPU RAM write address |
| cpuWrAllow | output | 1 | CPU write permitted |
| copWrEn | input | 1 | Coprocessor RAM write strobe |
| copAddr | input | RAM_AW | Coprocessor RAM write address |
| copWrAllow | output | 1 | Coprocessor write permitted |
| irq | output | 1 | Violation interrupt |

## Verification
The bench builds the unit with RAM_AW set to 8 and keeps the default 16-bit data bus and 0x11C register offset. With an 8-bit RAM address, the extreme addresses 0x00 and 0xFF are both cheap to drive. The bench can then place windows so that every inclusive edge and its neighbour on either side is probed. It can also build an empty window by setting the low bound above the high bound. The wider data bus shows that bound registers and the control register read back zero-extended.

// File: rtl/rwg_pkg.sv
package rwg_pkg;

  localparam int NUM_BOUNDS = 4;
  localparam int B_COP_LO   = 0;
  localparam int B_COP_HI   = 1;
  localparam int B_SH_LO    = 2;
  localparam int B_SH_HI    = 3;

  localparam int BIT_EN     = 7;
  localparam int BIT_IE     = 1;
  localparam int BIT_FLAG   = 0;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_CTRL  = 2'd1,
    RD_BOUND = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic                  ctrlWr;
    logic [NUM_BOUNDS-1:0] boundWr;
    rdSel_e                rdSel;
    logic [1:0]            boundIdx;
  } regStrobe_t;

endpackage

// File: rtl/rwg_ctrl.sv
module rwg_ctrl
  import rwg_pkg::*;
#(
  parameter int          REG_AW   = 12,
  parameter logic [11:0] CTRL_OFS = 12'h11C
) (
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [REG_AW-1:0] regAddr,
  output regStrobe_t        strobe
);

  localparam logic [REG_AW-1:0] CTRL_ADDR = REG_AW'(CTRL_OFS);

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = RD_NONE;
    if (regSel) begin
      if (regAddr == CTRL_ADDR) begin
        strobe.rdSel  = RD_CTRL;
        strobe.ctrlWr = regWrite;
      end
      for (int i = 0; i < NUM_BOUNDS; i++) begin
        if (regAddr == CTRL_ADDR + REG_AW'(i + 1)) begin
          strobe.rdSel      = RD_BOUND;
          strobe.boundIdx   = 2'(i);
          strobe.boundWr[i] = regWrite;
        end
      end
    end
  end

endmodule

// File: rtl/rwg_datapath.sv
module rwg_datapath
  import rwg_pkg::*;
#(
  parameter int RAM_AW = 16,
  parameter int DATA_W = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  regStrobe_t                          strobe,
  input  logic [DATA_W-1:0]                   regWdata,
  output logic [DATA_W-1:0]                   regRdata,
  input  logic                                cpuWrEn,
  input  logic [RAM_AW-1:0]                   cpuAddr,
  output logic                                cpuWrAllow,
  input  logic                                copWrEn,
  input  logic [RAM_AW-1:0]                   copAddr,
  output logic                                copWrAllow,
  output logic                                irq,
  output logic                                protEnQ,
  output logic                                irqEnQ,
  output logic                                violFlagQ,
  output logic [NUM_BOUNDS-1:0][RAM_AW-1:0]   boundQ
);

  function automatic logic inWindow(input logic [RAM_AW-1:0] a,
                                    input logic [RAM_AW-1:0] lo,
                                    input logic [RAM_AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic unusedWdata;
  assign unusedWdata = ^regWdata;

  // bound registers, frozen while protection is on
  for (genvar g = 0; g < NUM_BOUNDS; g++) begin : gBound
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        boundQ[g] <= '0;
      end else if (strobe.boundWr[g] && !protEnQ) begin
        boundQ[g] <= regWdata[RAM_AW-1:0];
      end
    end
  end

  logic cpuInCop, copInCop, copInShared, cpuViolation;

  always_comb begin
    cpuInCop     = inWindow(cpuAddr, boundQ[B_COP_LO], boundQ[B_COP_HI]);
    copInCop     = inWindow(copAddr, boundQ[B_COP_LO], boundQ[B_COP_HI]);
    copInShared  = inWindow(copAddr, boundQ[B_SH_LO],  boundQ[B_SH_HI]);
    cpuViolation = cpuWrEn && protEnQ && cpuInCop;
    cpuWrAllow   = cpuWrEn && !cpuViolation;
    copWrAllow   = copWrEn && (!protEnQ || copInCop || copInShared);
    irq          = irqEnQ && violFlagQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protEnQ   <= 1'b0;
      irqEnQ    <= 1'b0;
      violFlagQ <= 1'b0;
    end else begin
      if (strobe.ctrlWr) begin
        protEnQ <= regWdata[BIT_EN];
        irqEnQ  <= regWdata[BIT_IE];
      end
      if (cpuViolation) begin
        violFlagQ <= 1'b1;
      end else if (strobe.ctrlWr && regWdata[BIT_FLAG]) begin
        violFlagQ <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (strobe.rdSel)
      RD_CTRL:  regRdata = DATA_W'({protEnQ, 5'b00000, irqEnQ, violFlagQ});
      RD_BOUND: regRdata = DATA_W'(boundQ[strobe.boundIdx]);
      default:  regRdata = '0;
    endcase
  end

endmodule

// File: rtl/ram_write_guard.sv
module ram_write_guard
  import rwg_pkg::*;
#(
  parameter int          RAM_AW   = 16,
  parameter int          DATA_W   = 16,
  parameter int          REG_AW   = 12,
  parameter logic [11:0] CTRL_OFS = 12'h11C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              cpuWrEn,
  input  logic [RAM_AW-1:0] cpuAddr,
  output logic              cpuWrAllow,
  input  logic              copWrEn,
  input  logic [RAM_AW-1:0] copAddr,
  output logic              copWrAllow,
  output logic              irq
);

  regStrobe_t                          strobe;
  logic                                protEnQ, irqEnQ, violFlagQ;
  logic [NUM_BOUNDS-1:0][RAM_AW-1:0]   boundQ;

  rwg_ctrl #(
    .REG_AW  (REG_AW),
    .CTRL_OFS(CTRL_OFS)
  ) uCtrl (
    .regSel  (regSel),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  rwg_datapath #(
    .RAM_AW(RAM_AW),
    .DATA_W(DATA_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .cpuWrEn   (cpuWrEn),
    .cpuAddr   (cpuAddr),
    .cpuWrAllow(cpuWrAllow),
    .copWrEn   (copWrEn),
    .copAddr   (copAddr),
    .copWrAllow(copWrAllow),
    .irq       (irq),
    .protEnQ   (protEnQ),
    .irqEnQ    (irqEnQ),
    .violFlagQ (violFlagQ),
    .boundQ    (boundQ)
  );

endmodule

// File: rtl/rwg_checker.sv
module rwg_checker #(
  parameter int          RAM_AW   = 16,
  parameter int          REG_AW   = 12,
  parameter logic [11:0] CTRL_OFS = 12'h11C
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    regSel,
  input logic                    regWrite,
  input logic [REG_AW-1:0]       regAddr,
  input logic                    wdataLsb,
  input logic                    cpuWrEn,
  input logic                    cpuWrAllow,
  input logic                    copWrEn,
  input logic                    copWrAllow,
  input logic                    irq,
  input logic                    protEnQ,
  input logic                    violFlagQ,
  input logic [4*RAM_AW-1:0]     boundBits
);

  localparam logic [REG_AW-1:0] CTRL_ADDR = REG_AW'(CTRL_OFS);

  logic ctrlW1c, boundWrite, cpuBlocked;
  assign ctrlW1c    = regSel && regWrite && (regAddr == CTRL_ADDR) && wdataLsb;
  assign boundWrite = regSel && regWrite && (regAddr > CTRL_ADDR) &&
                      (regAddr <= CTRL_ADDR + REG_AW'(4));
  assign cpuBlocked = cpuWrEn && !cpuWrAllow;

  p_open_when_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    !protEnQ |-> (cpuWrAllow == cpuWrEn) && (copWrAllow == copWrEn));

  p_allow_needs_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuWrEn |-> !cpuWrAllow) and (!copWrEn |-> !copWrAllow));

  p_bounds_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    protEnQ && boundWrite |=> $stable(boundBits));

  p_cpu_block_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    cpuBlocked |=> violFlagQ);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    violFlagQ && !ctrlW1c |=> violFlagQ);

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    violFlagQ && ctrlW1c && !cpuBlocked |=> !violFlagQ);

  p_only_cpu_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    !violFlagQ && !cpuBlocked |=> !violFlagQ);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> violFlagQ);

endmodule

bind ram_write_guard rwg_checker #(
  .RAM_AW  (RAM_AW),
  .REG_AW  (REG_AW),
  .CTRL_OFS(CTRL_OFS)
) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .regSel    (regSel),
  .regWrite  (regWrite),
  .regAddr   (regAddr),
  .wdataLsb  (regWdata[0]),
  .cpuWrEn   (cpuWrEn),
  .cpuWrAllow(cpuWrAllow),
  .copWrEn   (copWrEn),
  .copWrAllow(copWrAllow),
  .irq       (irq),
  .protEnQ   (protEnQ),
  .violFlagQ (violFlagQ),
  .boundBits (boundQ)
);

// File: tb/tb_ram_write_guard.sv
`timescale 1ns/100ps
module tb_ram_write_guard;

  localparam int AW = 8;
  localparam logic [11:0] A_CTRL = 12'h11C;
  localparam logic [11:0] A_CLO  = 12'h11D;
  localparam logic [11:0] A_CHI  = 12'h11E;
  localparam logic [11:0] A_SLO  = 12'h11F;
  localparam logic [11:0] A_SHI  = 12'h120;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0, regWrite = 1'b0;
  logic [11:0] regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        cpuWrEn = 1'b0, copWrEn = 1'b0;
  logic [AW-1:0] cpuAddr = '0, copAddr = '0;
  logic        cpuWrAllow, copWrAllow, irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  ram_write_guard #(.RAM_AW(AW)) dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr), .cpuWrAllow(cpuWrAllow),
    .copWrEn(copWrEn), .copAddr(copAddr), .copWrAllow(copWrAllow),
    .irq(irq)
  );

  // {cpuEn, cpuAddr, copEn, copAddr, expCpuAllow, expCopAllow}
  // windows: coprocessor 0x40..0x7F, shared 0x80..0x9F, protection on
  localparam logic [19:0] VEC [10] = '{
    {1'b1, 8'h3F, 1'b1, 8'h40, 1'b1, 1'b1},
    {1'b1, 8'h40, 1'b1, 8'h7F, 1'b0, 1'b1},
    {1'b1, 8'h7F, 1'b1, 8'h80, 1'b0, 1'b1},
    {1'b1, 8'h80, 1'b1, 8'h9F, 1'b1, 1'b1},
    {1'b1, 8'hFF, 1'b1, 8'hA0, 1'b1, 1'b0},
    {1'b1, 8'h00, 1'b1, 8'h3F, 1'b1, 1'b0},
    {1'b0, 8'h50, 1'b1, 8'h00, 1'b0, 1'b0},
    {1'b1, 8'h60, 1'b0, 8'h60, 1'b0, 1'b0},
    {1'b1, 8'h41, 1'b1, 8'hFF, 1'b0, 1'b0},
    {1'b1, 8'h9F, 1'b1, 8'h8F, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0; regWdata = '0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b0; regAddr = a;
    #1 d = regRdata;
    regSel = 1'b0;
  endtask

  // hold a write strobe across exactly one rising edge
  task automatic cpuPulse(input logic [AW-1:0] a);
    @(negedge clk); cpuWrEn = 1'b1; cpuAddr = a;
    @(negedge clk); cpuWrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog run did not complete");
    finishRun();
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R2 reset state
    busRd(A_CTRL, rd); chk("R2", "ctrl after reset", rd, 16'h0000);
    chk("R2", "irq after reset", {15'd0, irq}, 16'd0);
    busRd(A_CLO, rd); chk("R2", "cop lo reset", rd, 16'h0000);
    busRd(A_CHI, rd); chk("R2", "cop hi reset", rd, 16'h0000);
    busRd(A_SHI, rd); chk("R2", "shared hi reset", rd, 16'h0000);

    // R3 disabled: everything open, no flag
    @(negedge clk);
    cpuWrEn = 1'b1; cpuAddr = 8'h00; copWrEn = 1'b1; copAddr = 8'hFF;
    #1 chk("R3", "cpu allow disabled", {15'd0, cpuWrAllow}, 16'd1);
    chk("R3", "cop allow disabled", {15'd0, copWrAllow}, 16'd1);
    @(negedge clk); cpuWrEn = 1'b0; copWrEn = 1'b0;
    busRd(A_CTRL, rd); chk("R3", "no flag while disabled", rd, 16'h0000);

    // R4 program bounds while disabled
    busWr(A_CLO, 16'h0040); busWr(A_CHI, 16'h007F);
    busWr(A_SLO, 16'h0080); busWr(A_SHI, 16'h009F);
    busRd(A_CHI, rd); chk("R4", "cop hi readback", rd, 16'h007F);
    busRd(A_SLO, rd); chk("R4", "shared lo readback", rd, 16'h0080);

    // R1 layout: unimplemented bits read zero
    busWr(A_CTRL, 16'h00FE);
    busRd(A_CTRL, rd); chk("R1", "ctrl reads en+ie only", rd, 16'h0082);

    // R5 R6 R11 vector table, strobes dropped before the edge
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      cpuWrEn = VEC[i][19]; cpuAddr = VEC[i][18:11];
      copWrEn = VEC[i][10]; copAddr = VEC[i][9:2];
      #1;
      chk("R5", $sformatf("cpu allow row %0d", i), {15'd0, cpuWrAllow}, {15'd0, VEC[i][1]});
      chk("R6", $sformatf("cop allow row %0d", i), {15'd0, copWrAllow}, {15'd0, VEC[i][0]});
      cpuWrEn = 1'b0; copWrEn = 1'b0;
    end
    busRd(A_CTRL, rd); chk("R11", "no flag from unclocked strobes", rd, 16'h0082);

    // R4 bounds locked while enabled
    busWr(A_CLO, 16'h0000);
    busRd(A_CLO, rd); chk("R4", "cop lo locked", rd, 16'h0040);

    // R7 coprocessor violation leaves flag clear
    @(negedge clk); copWrEn = 1'b1; copAddr = 8'hA0;
    @(negedge clk); copWrEn = 1'b0;
    busRd(A_CTRL, rd); chk("R7", "cop violation no flag", rd, 16'h0082);

    // R7 R9 CPU violation sets flag, irq follows
    cpuPulse(8'h50);
    #1 chk("R9", "irq with ie and flag", {15'd0, irq}, 16'd1);
    busRd(A_CTRL, rd); chk("R7", "cpu violation flag", rd, 16'h0083);

    // R8 write-zero no effect, write-one clears
    busWr(A_CTRL, 16'h0082);
    busRd(A_CTRL, rd); chk("R8", "write 0 keeps flag", rd, 16'h0083);
    busWr(A_CTRL, 16'h0083);
    busRd(A_CTRL, rd); chk("R8", "write 1 clears flag", rd, 16'h0082);
    chk("R9", "irq low after clear", {15'd0, irq}, 16'd0);

    // R9 irq masked by interrupt enable
    busWr(A_CTRL, 16'h0080);
    cpuPulse(8'h7F);
    busRd(A_CTRL, rd); chk("R7", "flag at hi edge", rd, 16'h0081);
    chk("R9", "irq masked", {15'd0, irq}, 16'd0);

    // R8 clear and violation in the same cycle: set wins
    busWr(A_CTRL, 16'h0081);
    busRd(A_CTRL, rd); chk("R8", "cleared before race", rd, 16'h0080);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regAddr = A_CTRL; regWdata = 16'h0081;
    cpuWrEn = 1'b1; cpuAddr = 8'h40;
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0; cpuWrEn = 1'b0;
    busRd(A_CTRL, rd); chk("R8", "set wins over clear", rd, 16'h0081);

    // disable, bounds writable again, R10 empty windows
    busWr(A_CTRL, 16'h0001);
    busRd(A_CTRL, rd); chk("R3", "disabled and cleared", rd, 16'h0000);
    busWr(A_CLO, 16'h0060); busWr(A_CHI, 16'h0050);
    busWr(A_SLO, 16'h00FF); busWr(A_SHI, 16'h0000);
    busRd(A_CLO, rd); chk("R4", "cop lo writable again", rd, 16'h0060);
    busWr(A_CTRL, 16'h0080);
    @(negedge clk);
    cpuWrEn = 1'b1; cpuAddr = 8'h55; copWrEn = 1'b1; copAddr = 8'h55;
    #1 chk("R10", "cpu allowed empty cop window", {15'd0, cpuWrAllow}, 16'd1);
    chk("R10", "cop blocked both empty", {15'd0, copWrAllow}, 16'd0);
    copAddr = 8'h60; cpuAddr = 8'h60;
    #0.5 chk("R10", "cop blocked at lo of empty", {15'd0, copWrAllow}, 16'd0);
    chk("R10", "cpu allowed at lo of empty", {15'd0, cpuWrAllow}, 16'd1);
    @(negedge clk); cpuWrEn = 1'b0; copWrEn = 1'b0;
    busRd(A_CTRL, rd); chk("R10", "no flag for empty window", rd, 16'h0080);

    finishRun();
  end

endmodule